// File: doc/BRIEF.md
# Single-Cycle Load/Store Subset Processor

This block is a 32-bit processor core that runs a nine-instruction load/store subset (register add, subtract, AND, OR and signed set-less-than, plus word load, word store, branch-if-equal and unconditional jump) and retires one instruction on every clock edge. It holds the program counter, a 32-entry register file, the immediate sign extender, the ALU with its operation decoder, the main control decoder and the logic that forms the next PC from the sequential, branch and jump candidates.

The core drives an instruction address and expects the instruction word back in the same cycle; it drives a data address, write data and one-hot read/write enables to data memory and expects load data back in the same cycle. Stores are committed by the memory on the clock edge that retires the store. Any encoding outside the subset retires as a no-op.

Top module: `mcpu_core`

## Requirements
- R1: While `rst` is high at a rising clock edge the PC becomes 0; `imem_addr` always shows the PC.
- R2: An instruction that is neither a taken branch nor a jump advances the PC by 4.
- R3: Opcode (bits 31:26) 0 with funct (bits 5:0) 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs−rt, rs AND rt or rs OR rt into register rd (bits 15:11); rs is bits 25:21, rt bits 20:16.
- R4: Opcode 0 with funct 0x2A writes 1 into rd when rs is less than rt as two's-complement numbers, otherwise 0.
- R5: Opcode 0x23 drives `dmem_addr` = rs + sign-extended bits 15:0, raises `dmem_re`, and writes `dmem_rdata` into register rt.
- R6: Opcode 0x2B drives the same address form, puts rt on `dmem_wdata`, raises `dmem_we`, and writes no register; `dmem_we` and `dmem_re` are never high together.
- R7: Opcode 0x04 sets the PC to PC+4 + (sign-extended bits 15:0 shifted left 2) when rs equals rt, and to PC+4 otherwise; negative offsets branch backward.
- R8: Opcode 0x02 sets the PC to the upper four PC bits followed by bits 25:0 and two zero bits.
- R9: Register 0 reads as zero; R-type and load writes that name it leave it zero.
- R10: Any other opcode, and opcode 0 with any other funct, writes no register, raises neither memory enable and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address (current PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| dmem_re | output | 1 | Load in progress |
| dmem_we | output | 1 | Store to commit at this clock edge |

## Verification
The embedded properties watch every cycle for the PC relations: reset to zero, the step of 4 after non-control instructions, the backward or forward branch target when the two operands compare equal, the jump target formed from the PC, and that memory enables are exclusive and a store only comes from the store opcode; the register file also checks that a written nonzero register reads back its value. Arithmetic results, the signed comparison over boundary operands, the zero register surviving writes, and unknown encodings leaving registers untouched are visible only through the bench's programs, which store every result to its memory model and compare against values computed from the operands.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned OPC_W  = 6;
    localparam int unsigned FN_W   = 6;
    localparam int unsigned RIDX_W = 5;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned JT_W   = 26;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_sel_e;

    typedef struct packed {
        logic     rf_we;
        logic     dst_is_rd;
        logic     wb_from_mem;
        logic     mem_rd;
        logic     mem_wr;
        logic     b_is_imm;
        logic     is_branch;
        logic     is_jump;
        alu_sel_e alu_sel;
    } ctrl_t;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [FN_W-1:0]   fn;
        logic [IMM_W-1:0]  imm;
        logic [JT_W-1:0]   jt;
    } fields_t;

    function automatic fields_t split_word(input logic [WORD_W-1:0] w);
        fields_t f;
        f.opc = w[31:26];
        f.rs  = w[25:21];
        f.rt  = w[20:16];
        f.rd  = w[15:11];
        f.fn  = w[5:0];
        f.imm = w[15:0];
        f.jt  = w[25:0];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    localparam ctrl_t CTRL_NOP = '{
        rf_we: 1'b0, dst_is_rd: 1'b0, wb_from_mem: 1'b0, mem_rd: 1'b0,
        mem_wr: 1'b0, b_is_imm: 1'b0, is_branch: 1'b0, is_jump: 1'b0,
        alu_sel: ALU_ADD
    };

endpackage

// File: rtl/mcpu_decode.sv
module mcpu_decode
    import mcpu_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [FN_W-1:0]  fn,
    output ctrl_t            ctl
);

    alu_sel_e rtype_sel;
    logic     rtype_ok;

    // funct decode for register-register operations
    always_comb begin
        rtype_ok  = 1'b1;
        rtype_sel = ALU_ADD;
        unique case (fn)
            FN_ADD:  rtype_sel = ALU_ADD;
            FN_SUB:  rtype_sel = ALU_SUB;
            FN_AND:  rtype_sel = ALU_AND;
            FN_OR:   rtype_sel = ALU_OR;
            FN_SLT:  rtype_sel = ALU_SLT;
            default: rtype_ok  = 1'b0;
        endcase
    end

    // main decode; anything unlisted retires as a no-op
    always_comb begin
        ctl = CTRL_NOP;
        unique case (opc)
            OPC_RTYPE: begin
                if (rtype_ok) begin
                    ctl.rf_we     = 1'b1;
                    ctl.dst_is_rd = 1'b1;
                    ctl.alu_sel   = rtype_sel;
                end
            end
            OPC_LOAD: begin
                ctl.rf_we       = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.mem_rd      = 1'b1;
                ctl.b_is_imm    = 1'b1;
                ctl.alu_sel     = ALU_ADD;
            end
            OPC_STORE: begin
                ctl.mem_wr   = 1'b1;
                ctl.b_is_imm = 1'b1;
                ctl.alu_sel  = ALU_ADD;
            end
            OPC_BEQ: begin
                ctl.is_branch = 1'b1;
                ctl.alu_sel   = ALU_SUB;
            end
            OPC_JUMP: begin
                ctl.is_jump = 1'b1;
            end
            default: ctl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned W     = 32,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] cells [NREGS];

    // entry 0 is hard-wired; the others hold state
    generate
        for (genvar i = 0; i < NREGS; i++) begin : g_cell
            if (i == 0) begin : g_zero
                assign cells[i] = '0;
            end else begin : g_store
                always_ff @(posedge clk) begin
                    if (rst)
                        cells[i] <= '0;
                    else if (we && wa == AW'(i))
                        cells[i] <= wd;
                end
            end
        end
    endgenerate

    assign rd_a = cells[ra_a];
    assign rd_b = cells[ra_b];

    // R3
    rf_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> (ra_a != $past(wa)) || (rd_a == $past(wd)));

    // R9
    rf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ra_b == '0) |-> (rd_b == '0));

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  alu_sel_e      sel,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y,
    output logic          zero
);

    logic [W-1:0] diff;
    logic         lt_signed;

    assign diff = a - b;
    // signed less-than from the sign bits and the difference
    assign lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];

    always_comb begin
        unique case (sel)
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter int unsigned NREGS = 32,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_data,
    output logic [WORD_W-1:0] dmem_addr,
    output logic [WORD_W-1:0] dmem_wdata,
    input  logic [WORD_W-1:0] dmem_rdata,
    output logic              dmem_re,
    output logic              dmem_we
);

    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] pc_next;
    logic [WORD_W-1:0] pc_seq;
    logic [WORD_W-1:0] pc_br;
    logic [WORD_W-1:0] pc_jmp;
    fields_t           f;
    ctrl_t             ctl;
    logic [WORD_W-1:0] imm_x;
    logic [WORD_W-1:0] rs_val;
    logic [WORD_W-1:0] rt_val;
    logic [WORD_W-1:0] alu_b;
    logic [WORD_W-1:0] alu_y;
    logic              alu_z;
    logic [WORD_W-1:0] wb_val;
    logic [AW-1:0]     wb_idx;

    assign f     = split_word(imem_data);
    assign imm_x = sext_imm(f.imm);

    mcpu_decode u_dec (
        .opc (f.opc),
        .fn  (f.fn),
        .ctl (ctl)
    );

    mcpu_regfile #(.NREGS(NREGS), .W(WORD_W)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (AW'(f.rs)),
        .ra_b (AW'(f.rt)),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (ctl.rf_we),
        .wa   (wb_idx),
        .wd   (wb_val)
    );

    assign alu_b = ctl.b_is_imm ? imm_x : rt_val;

    mcpu_alu #(.W(WORD_W)) u_alu (
        .sel  (ctl.alu_sel),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_z)
    );

    // destination select and write-back select
    assign wb_idx = ctl.dst_is_rd ? AW'(f.rd) : AW'(f.rt);
    assign wb_val = ctl.wb_from_mem ? dmem_rdata : alu_y;

    // data memory side
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_re    = ctl.mem_rd;
    assign dmem_we    = ctl.mem_wr;

    // next-PC candidates
    assign pc_seq = pc_q + WORD_W'(4);
    assign pc_br  = pc_seq + {imm_x[WORD_W-3:0], 2'b00};
    assign pc_jmp = {pc_q[WORD_W-1:WORD_W-4], f.jt, 2'b00};

    always_comb begin
        if (ctl.is_jump)
            pc_next = pc_jmp;
        else if (ctl.is_branch && alu_z)
            pc_next = pc_br;
        else
            pc_next = pc_seq;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= pc_next;
    end

    assign imem_addr = pc_q;

    // R1
    pc_reset_chk: assert property (@(posedge clk)
        rst |=> (imem_addr == '0));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_data[31:26] != OPC_JUMP && imem_data[31:26] != OPC_BEQ)
        |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R7
    br_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_data[31:26] == OPC_BEQ && rs_val == rt_val)
        |=> (imem_addr == $past(imem_addr) + 32'd4
                          + {{14{$past(imem_data[15])}}, $past(imem_data[15:0]), 2'b00}));

    // R8
    jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (imem_data[31:26] == OPC_JUMP)
        |=> (imem_addr == {$past(imem_addr[31:28]), $past(imem_data[25:0]), 2'b00}));

    // R6
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(dmem_we && dmem_re));

    // R10
    store_src_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (imem_data[31:26] == OPC_STORE));

endmodule

// File: tb/sim_mcpu_core.sv
module sim_mcpu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic [31:0] dmem_rdata;
    logic        dmem_re;
    logic        dmem_we;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [31:0] prog [64];
    logic [31:0] dm   [16];
    logic [31:0] pre  [16];
    logic        pre_go = 1'b0;

    localparam logic [31:0] SENT = 32'hDEADBEEF;

    always #10 clk = ~clk;

    mcpu_core u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_re    (dmem_re),
        .dmem_we    (dmem_we)
    );

    assign imem_data  = (imem_addr[31:8] == 24'd0) ? prog[imem_addr[7:2]] : 32'd0;
    assign dmem_rdata = dm[dmem_addr[5:2]];

    always @(posedge clk) begin
        if (pre_go) begin
            for (int i = 0; i < 16; i++) dm[i] <= pre[i];
        end else if (dmem_we) begin
            dm[dmem_addr[5:2]] <= dmem_wdata;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(input int tgt);
        return {6'h02, 26'(tgt)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // reset with memory preload; R1 checked while reset is held
    task automatic do_reset();
        @(negedge clk);
        rst    = 1'b1;
        pre_go = 1'b1;
        @(negedge clk);
        chk("R1 pc after reset", imem_addr, 32'd0);
        pre_go = 1'b0;
        rst    = 1'b0;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 32'd0;
    endtask

    task automatic load_sweep_prog();
        clear_prog();
        prog[0]  = enc_i(6'h23, 0, 1, 16'd0);
        prog[1]  = enc_i(6'h23, 0, 2, 16'd4);
        prog[2]  = enc_r(1, 2, 3, 6'h20);
        prog[3]  = enc_i(6'h2B, 0, 3, 16'd8);
        prog[4]  = enc_r(1, 2, 3, 6'h22);
        prog[5]  = enc_i(6'h2B, 0, 3, 16'd12);
        prog[6]  = enc_r(1, 2, 3, 6'h24);
        prog[7]  = enc_i(6'h2B, 0, 3, 16'd16);
        prog[8]  = enc_r(1, 2, 3, 6'h25);
        prog[9]  = enc_i(6'h2B, 0, 3, 16'd20);
        prog[10] = enc_r(1, 2, 3, 6'h2A);
        prog[11] = enc_i(6'h2B, 0, 3, 16'd24);
        prog[12] = enc_r(1, 2, 0, 6'h20);
        prog[13] = enc_i(6'h2B, 0, 0, 16'd28);
        prog[14] = enc_i(6'h23, 0, 0, 16'd0);
        prog[15] = enc_i(6'h2B, 0, 0, 16'd32);
        prog[16] = enc_i(6'h3F, 2, 1, 16'h0040);
        prog[17] = enc_r(2, 2, 1, 6'h00);
        prog[18] = enc_i(6'h2B, 0, 1, 16'd36);
        prog[19] = enc_i(6'h23, 0, 5, 16'd40);
        prog[20] = enc_i(6'h2B, 5, 2, 16'hFFFC);
        prog[21] = enc_j(21);
    endtask

    task automatic load_branch_prog();
        clear_prog();
        prog[0] = enc_i(6'h23, 0, 1, 16'd0);
        prog[1] = enc_i(6'h23, 0, 2, 16'd4);
        prog[2] = enc_i(6'h04, 1, 2, 16'd2);
        prog[3] = enc_i(6'h2B, 0, 1, 16'd8);
        prog[4] = enc_j(6);
        prog[5] = enc_i(6'h2B, 0, 2, 16'd12);
        prog[6] = enc_i(6'h04, 0, 0, 16'hFFFF);
    endtask

    task automatic run_sweep(input logic [31:0] a, input logic [31:0] b, input bit trace);
        logic [31:0] slt_exp;
        for (int i = 0; i < 16; i++) pre[i] = SENT;
        pre[0]  = a;
        pre[1]  = b;
        pre[10] = 32'd48;
        do_reset();
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            if (trace && k <= 21) chk("R2 sequential pc", imem_addr, 32'(4 * k));
        end
        slt_exp = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        chk("R3 add",  dm[2], a + b);
        chk("R3 sub",  dm[3], a - b);
        chk("R3 and",  dm[4], a & b);
        chk("R3 or",   dm[5], a | b);
        chk("R4 slt",  dm[6], slt_exp);
        chk("R9 r0 after alu write",  dm[7], 32'd0);
        chk("R9 r0 after load write", dm[8], 32'd0);
        chk("R10 unknown encodings keep r1", dm[9], a);
        chk("R5 R6 offset addressing", dm[11], b);
        chk("R8 jump to self", imem_addr, 32'd84);
        chk("R6 store enable low at rest", {31'd0, dmem_we}, 32'd0);
    endtask

    task automatic run_branch(input logic [31:0] a, input logic [31:0] b);
        bit eq;
        eq = (a == b);
        for (int i = 0; i < 16; i++) pre[i] = SENT;
        pre[0] = a;
        pre[1] = b;
        do_reset();
        for (int k = 1; k <= 3; k++) @(negedge clk);
        chk("R7 pc after beq", imem_addr, eq ? 32'd20 : 32'd12);
        for (int k = 4; k <= 10; k++) @(negedge clk);
        chk("R7 not-taken path store", dm[2], eq ? SENT : a);
        chk("R7 taken path store",     dm[3], eq ? b : SENT);
        chk("R7 backward self branch", imem_addr, 32'd24);
    endtask

    logic [31:0] vals [8];

    initial begin
        vals[0] = 32'h0000_0000;
        vals[1] = 32'h0000_0001;
        vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF;
        vals[4] = 32'h8000_0000;
        vals[5] = 32'h0000_0005;
        vals[6] = 32'hFFFF_FFFB;
        vals[7] = 32'h1234_5678;
        for (int i = 0; i < 16; i++) pre[i] = SENT;
        clear_prog();

        load_sweep_prog();
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                run_sweep(vals[i], vals[j], (i == 0 && j == 0));
            end
        end

        load_branch_prog();
        run_branch(32'd3, 32'd3);
        run_branch(32'd3, 32'd4);
        run_branch(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_branch(32'h8000_0000, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule